// File: doc/BRIEF.md
# Scanline Capture Blend Unit

This block writes one captured video line at a time into a memory bank. After a line-start pulse it steps across the line one pixel per clock. For each pixel it takes a rendered 15-bit colour from source A and a 16-bit stored word from source B. It then writes one of three things: the A colour, an unchanged copy of the B word, or a per-channel weighted mix of the two. Source B pixels come from memory, so the unit also presents a read address for every pixel slot.

A control word sets the two mix weights, the source selection, the capture size, and separate 32 KiB segment offsets for writing and for reading. The size code can halve the line width or limit capture to the upper part of the frame. Two qualifier inputs report whether the destination bank and the source-B bank are mapped for direct processor access. A line that cannot be captured produces no writes, only a completion pulse. The control word, line number and qualifiers are sampled on the line-start pulse and held for the whole line.

Top module: `capture_unit`

## Requirements
- R1: After reset, `wr_en_o`, `done_o` and `pix_take_o` are all low.
- R2: The selection code is control bits 13:12. With selection 0, each write carries `{1'b1, pix_a_i}`. The source-A colour has red in bits 4:0, green in bits 9:5 and blue in bits 14:10.
- R3: With selection 1, each write carries `pix_b_i` exactly as presented, including its bit 15.
- R4: With selection 2 or 3, each 5-bit channel written is floor((A·wa + B·wb)/16), saturated to 31. Here wa is control bits 4:0 and wb is control bits 9:5. Bit 15 of the written word is 1.
- R5: A weight above 16 acts as exactly 16.
- R6: The size code is control bits 11:10. Code 0 captures 128 pixels on every line. Code 3 captures 256 pixels on every line.
- R7: Code 1 captures 256 pixels only on lines below 64. Code 2 captures 256 pixels only on lines below 128. Any other line gives no write.
- R8: The write byte address for pixel x on line y is ((x + y·W)·2 + woff·32768) mod 131072. W is the captured width and woff is control bits 15:14.
- R9: The read address in a pixel slot is ((x + y·256)·2 + roff·32768) mod 131072, where roff is control bits 17:16.
- R10: If `dst_cpu_i` is low, a line writes nothing in any mode. If `src_b_cpu_i` is low, selections 1 to 3 write nothing, but selection 0 still captures.
- R11: A pulse on `line_start_i` is sampled at a clock edge. For a captured line, pixel slot x is the (x+1)-th cycle after that edge, with `pix_take_o` high. The write for slot x appears one cycle later. `done_o` is high together with the last write. For a skipped line, `done_o` is high in the first cycle after the sampling edge and `pix_take_o` stays low.
- R12: Control word, line number and both qualifiers are sampled only with `line_start_i`. Changes to them during a line have no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Starts the capture of one line |
| line_i | input | 9 | Line number y |
| ctrl_i | input | 18 | Control word (fields in R2, R4, R6, R8, R9) |
| dst_cpu_i | input | 1 | Destination bank is mapped for direct processor access |
| src_b_cpu_i | input | 1 | Source-B bank is mapped for direct processor access |
| pix_take_o | output | 1 | Pixel slot: the sources must present the pixel this cycle |
| rd_addr_o | output | 17 | Source-B byte read address for the current slot |
| pix_a_i | input | 15 | Source-A colour for the current slot |
| pix_b_i | input | 16 | Source-B word for the current slot |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | 17 | Memory write byte address |
| wr_data_o | output | 16 | Memory write data |
| done_o | output | 1 | Line finished, written or skipped |

## Verification
The assertions assume three things about the environment. `line_start_i` is only pulsed while no line is in progress. Both pixel inputs hold the values for the slot in every cycle where `pix_take_o` is high. Reset spans at least one clock edge. The bench meets the first condition by waiting for `done_o` before pulsing the next line. It meets the second by driving fresh random pixels at each falling edge of a slot. It also scrambles the control word, line number and qualifiers right after each pulse, so any late sampling would show up.

// File: rtl/cap_pkg.sv
package cap_pkg;
    parameter int FULL_W  = 256;
    parameter int LINE_W  = 9;
    parameter int ADDR_W  = 17;
    parameter int CH_W    = 5;
    parameter int WGT_W   = 5;
    parameter int WGT_MAX = 16;
    parameter int OFF_W   = 2;
    parameter int ROWS_A  = 64;
    parameter int ROWS_B  = 128;

    localparam int X_W    = $clog2(FULL_W);
    localparam int PIX_W  = 3 * CH_W;
    localparam int WORD_W = PIX_W + 1;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_COPY = 2'd1,
        SEL_MIX  = 2'd2,
        SEL_MIX2 = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        SZ_HALF = 2'd0,
        SZ_R64  = 2'd1,
        SZ_R128 = 2'd2,
        SZ_FULL = 2'd3
    } size_e;

    typedef struct packed {
        logic [OFF_W-1:0] roff;
        logic [OFF_W-1:0] woff;
        sel_e             sel;
        size_e            size;
        logic [WGT_W-1:0] wb;
        logic [WGT_W-1:0] wa;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cap_blend.sv
module cap_blend #(
    parameter int CH_W    = 5,
    parameter int WGT_W   = 5,
    parameter int WGT_MAX = 16
) (
    input  logic [3*CH_W-1:0] a_i,
    input  logic [3*CH_W-1:0] b_i,
    input  logic [WGT_W-1:0]  wa_i,
    input  logic [WGT_W-1:0]  wb_i,
    output logic [3*CH_W-1:0] mix_o
);
    localparam int SH     = $clog2(WGT_MAX);
    localparam int SUM_W  = CH_W + WGT_W + 1;
    localparam int CH_MAX = (1 << CH_W) - 1;

    logic [WGT_W-1:0] wa_c;
    logic [WGT_W-1:0] wb_c;

    // weights saturate at the unity value
    assign wa_c = (wa_i > WGT_W'(WGT_MAX)) ? WGT_W'(WGT_MAX) : wa_i;
    assign wb_c = (wb_i > WGT_W'(WGT_MAX)) ? WGT_W'(WGT_MAX) : wb_i;

    for (genvar c = 0; c < 3; c++) begin : g_ch
        logic [SUM_W-1:0] sum;
        logic [SUM_W-1:0] scaled;
        assign sum = SUM_W'(a_i[c*CH_W +: CH_W]) * SUM_W'(wa_c)
                   + SUM_W'(b_i[c*CH_W +: CH_W]) * SUM_W'(wb_c);
        assign scaled = sum >> SH;
        assign mix_o[c*CH_W +: CH_W] = (scaled > SUM_W'(CH_MAX)) ?
                                       CH_W'(CH_MAX) : scaled[CH_W-1:0];
    end
endmodule

// File: rtl/cap_addr.sv
module cap_addr #(
    parameter int X_W    = 8,
    parameter int LINE_W = 9,
    parameter int ADDR_W = 17,
    parameter int OFF_W  = 2
) (
    input  logic [X_W-1:0]    x_i,
    input  logic [LINE_W-1:0] y_i,
    input  logic              half_i,
    input  logic [OFF_W-1:0]  woff_i,
    input  logic [OFF_W-1:0]  roff_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [ADDR_W-1:0] rd_addr_o
);
    localparam int SEG_SH = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] idx_w;
    logic [ADDR_W-1:0] idx_r;

    always_comb begin
        idx_w = half_i ? (ADDR_W'(y_i) << (X_W - 1)) : (ADDR_W'(y_i) << X_W);
        idx_w = idx_w + ADDR_W'(x_i);
        idx_r = (ADDR_W'(y_i) << X_W) + ADDR_W'(x_i);
        // halfword index doubled; overflow past the bank wraps
        wr_addr_o = (idx_w << 1) + (ADDR_W'(woff_i) << SEG_SH);
        rd_addr_o = (idx_r << 1) + (ADDR_W'(roff_i) << SEG_SH);
    end
endmodule

// File: rtl/capture_unit.sv
module capture_unit
    import cap_pkg::*;
#(
    parameter int P_FULL_W = cap_pkg::FULL_W,
    parameter int P_LINE_W = cap_pkg::LINE_W,
    parameter int P_ADDR_W = cap_pkg::ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_start_i,
    input  logic [P_LINE_W-1:0] line_i,
    input  logic [CTRL_W-1:0]   ctrl_i,
    input  logic                dst_cpu_i,
    input  logic                src_b_cpu_i,
    output logic                pix_take_o,
    output logic [P_ADDR_W-1:0] rd_addr_o,
    input  logic [PIX_W-1:0]    pix_a_i,
    input  logic [WORD_W-1:0]   pix_b_i,
    output logic                wr_en_o,
    output logic [P_ADDR_W-1:0] wr_addr_o,
    output logic [WORD_W-1:0]   wr_data_o,
    output logic                done_o
);
    localparam int PX_W      = $clog2(P_FULL_W);
    localparam int FULL_LAST = P_FULL_W - 1;
    localparam int HALF_LAST = P_FULL_W / 2 - 1;

    typedef struct packed {
        logic                active;
        logic [PX_W-1:0]     x;
        ctrl_t               ctl;
        logic [P_LINE_W-1:0] y;
        logic                wr_en;
        logic [P_ADDR_W-1:0] wr_addr;
        logic [WORD_W-1:0]   wr_data;
        logic                done;
    } state_t;

    state_t st_d, st_q;

    ctrl_t               ctl_in;
    logic [PIX_W-1:0]    mix;
    logic [P_ADDR_W-1:0] wr_addr_c;
    logic [P_ADDR_W-1:0] rd_addr_c;
    logic [WORD_W-1:0]   pix_c;
    logic                last_c;
    logic                row_ok_c;
    logic                go_c;

    assign ctl_in = ctrl_t'(ctrl_i);

    cap_blend #(
        .CH_W   (CH_W),
        .WGT_W  (WGT_W),
        .WGT_MAX(WGT_MAX)
    ) u_blend (
        .a_i  (pix_a_i),
        .b_i  (pix_b_i[PIX_W-1:0]),
        .wa_i (st_q.ctl.wa),
        .wb_i (st_q.ctl.wb),
        .mix_o(mix)
    );

    cap_addr #(
        .X_W   (PX_W),
        .LINE_W(P_LINE_W),
        .ADDR_W(P_ADDR_W),
        .OFF_W (OFF_W)
    ) u_addr (
        .x_i      (st_q.x),
        .y_i      (st_q.y),
        .half_i   (st_q.ctl.size == SZ_HALF),
        .woff_i   (st_q.ctl.woff),
        .roff_i   (st_q.ctl.roff),
        .wr_addr_o(wr_addr_c),
        .rd_addr_o(rd_addr_c)
    );

    always_comb begin
        // pixel word for the current slot
        unique case (st_q.ctl.sel)
            SEL_A:    pix_c = {1'b1, pix_a_i};
            SEL_COPY: pix_c = pix_b_i;
            default:  pix_c = {1'b1, mix};
        endcase

        last_c = (st_q.ctl.size == SZ_HALF) ? (st_q.x == PX_W'(HALF_LAST))
                                            : (st_q.x == PX_W'(FULL_LAST));

        unique case (ctl_in.size)
            SZ_R64:  row_ok_c = line_i < P_LINE_W'(ROWS_A);
            SZ_R128: row_ok_c = line_i < P_LINE_W'(ROWS_B);
            default: row_ok_c = 1'b1;
        endcase
        go_c = dst_cpu_i && row_ok_c && ((ctl_in.sel == SEL_A) || src_b_cpu_i);

        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.done  = 1'b0;
        if (st_q.active) begin
            st_d.wr_en   = 1'b1;
            st_d.wr_addr = wr_addr_c;
            st_d.wr_data = pix_c;
            if (last_c) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end else begin
                st_d.x = st_q.x + 1'b1;
            end
        end else if (line_start_i) begin
            st_d.ctl    = ctl_in;
            st_d.y      = line_i;
            st_d.x      = '0;
            st_d.active = go_c;
            st_d.done   = !go_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix_take_o = st_q.active;
    assign rd_addr_o  = rd_addr_c;
    assign wr_en_o    = st_q.wr_en;
    assign wr_addr_o  = st_q.wr_addr;
    assign wr_data_o  = st_q.wr_data;
    assign done_o     = st_q.done;

    // slots advance by exactly one pixel per clock
    assert_slot_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active && !last_c |=> st_q.active && (st_q.x == $past(st_q.x) + 1'b1));

    // completion never overlaps an open line
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !pix_take_o);

    // back-to-back writes of one line are consecutive halfwords
    assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o && $past(wr_en_o) |-> wr_addr_o == $past(wr_addr_o) + P_ADDR_W'(2));

    // copy writes the stored word untouched
    assert_copy_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o && st_q.ctl.sel == SEL_COPY |-> wr_data_o == $past(pix_b_i));

    // source A keeps its colour and gains the top bit
    assert_src_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o && st_q.ctl.sel == SEL_A |-> wr_data_o == {1'b1, $past(pix_a_i)});

    // an unmapped destination never opens a line
    assert_dst_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_i && !pix_take_o && !dst_cpu_i |=> !pix_take_o && done_o);

    // line parameters hold while the line runs
    assert_ctl_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pix_take_o && $past(pix_take_o) |-> $stable(st_q.ctl) && $stable(st_q.y));
endmodule

// File: tb/capture_unit_test.sv
module capture_unit_test;
    import cap_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line_start_i = 1'b0;
    logic [8:0]        line_i = '0;
    logic [17:0]       ctrl_i = '0;
    logic              dst_cpu_i = 1'b0;
    logic              src_b_cpu_i = 1'b0;
    logic              pix_take_o;
    logic [16:0]       rd_addr_o;
    logic [14:0]       pix_a_i = '0;
    logic [15:0]       pix_b_i = '0;
    logic              wr_en_o;
    logic [16:0]       wr_addr_o;
    logic [15:0]       wr_data_o;
    logic              done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    capture_unit uut (
        .clk(clk), .rst_n(rst_n), .line_start_i(line_start_i), .line_i(line_i),
        .ctrl_i(ctrl_i), .dst_cpu_i(dst_cpu_i), .src_b_cpu_i(src_b_cpu_i),
        .pix_take_o(pix_take_o), .rd_addr_o(rd_addr_o), .pix_a_i(pix_a_i),
        .pix_b_i(pix_b_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    function automatic logic [17:0] mk(int wa, int wb, int size, int sel, int woff, int roff);
        logic [17:0] c;
        c[4:0] = 5'(wa); c[9:5] = 5'(wb); c[11:10] = 2'(size);
        c[13:12] = 2'(sel); c[15:14] = 2'(woff); c[17:16] = 2'(roff);
        return c;
    endfunction

    function automatic logic [15:0] exp_pix(logic [17:0] c, logic [14:0] a, logic [15:0] b);
        int wa, wb, r;
        logic [15:0] o;
        if (c[13:12] == 2'd0) return {1'b1, a};
        if (c[13:12] == 2'd1) return b;
        wa = int'(c[4:0]); wb = int'(c[9:5]);
        if (wa > 16) wa = 16;
        if (wb > 16) wb = 16;
        o = 16'h8000;
        for (int k = 0; k < 3; k++) begin
            r = (int'(a[k*5 +: 5]) * wa + int'(b[k*5 +: 5]) * wb) / 16;
            if (r > 31) r = 31;
            o[k*5 +: 5] = 5'(r);
        end
        return o;
    endfunction

    function automatic logic [16:0] exp_wr(int x, int y, int w, int woff);
        return 17'(((x + y * w) * 2 + woff * 32768) % 131072);
    endfunction

    function automatic logic [16:0] exp_rd(int x, int y, int roff);
        return 17'(((x + y * 256) * 2 + roff * 32768) % 131072);
    endfunction

    task automatic run_line(input logic [17:0] c, input int y, input bit dok, input bit bok);
        int size, sel, w;
        bit cap;
        string dreq;
        logic [16:0] pa;
        logic [15:0] pd;
        size = int'(c[11:10]); sel = int'(c[13:12]);
        w = (size == 0) ? 128 : 256;
        cap = dok && (sel == 0 || bok) &&
              !(size == 1 && y >= 64) && !(size == 2 && y >= 128);
        dreq = (sel == 0) ? "R2" : (sel == 1) ? "R3" : "R4";
        @(negedge clk);
        line_start_i = 1'b1; line_i = 9'(y); ctrl_i = c;
        dst_cpu_i = dok; src_b_cpu_i = bok;
        @(negedge clk);
        line_start_i = 1'b0;
        // R12: scramble everything sampled at line start
        ctrl_i = 18'($urandom); line_i = 9'($urandom);
        dst_cpu_i = 1'($urandom); src_b_cpu_i = 1'($urandom);
        if (!cap) begin
            chk(done_o == 1'b1, "R7_R10", "skip done", 32'(done_o), 1);
            chk(wr_en_o == 1'b0 && pix_take_o == 1'b0, "R10", "skip no write",
                {30'b0, wr_en_o, pix_take_o}, 0);
            return;
        end
        for (int x = 0; x < w; x++) begin
            chk(pix_take_o == 1'b1, "R11", "slot", 32'(pix_take_o), 1);
            chk(rd_addr_o == exp_rd(x, y, int'(c[17:16])), "R9", "read addr",
                32'(rd_addr_o), 32'(exp_rd(x, y, int'(c[17:16]))));
            if (x > 0) begin
                chk(wr_en_o && !done_o && wr_addr_o == pa, "R8", "write addr",
                    32'(wr_addr_o), 32'(pa));
                chk(wr_data_o == pd, dreq, "write data", 32'(wr_data_o), 32'(pd));
            end else begin
                chk(wr_en_o == 1'b0, "R11", "no early write", 32'(wr_en_o), 0);
            end
            pix_a_i = 15'($urandom); pix_b_i = 16'($urandom);
            pa = exp_wr(x, y, w, int'(c[15:14]));
            pd = exp_pix(c, pix_a_i, pix_b_i);
            @(negedge clk);
        end
        chk(wr_en_o && done_o && wr_addr_o == pa, "R11", "last write with done",
            {wr_en_o, done_o, 13'b0, wr_addr_o}, {2'b11, 13'b0, pa});
        chk(wr_data_o == pd, dreq, "last data", 32'(wr_data_o), 32'(pd));
        chk(pix_take_o == 1'b0, "R6", "width end", 32'(pix_take_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R11", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!wr_en_o && !done_o && !pix_take_o, "R1", "reset outputs",
            {29'b0, wr_en_o, done_o, pix_take_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_en_o && !done_o && !pix_take_o, "R1", "idle after reset",
            {29'b0, wr_en_o, done_o, pix_take_o}, 0);

        run_line(mk(3, 7, 3, 0, 0, 0), 0, 1, 1);      // R2 full width
        run_line(mk(0, 0, 0, 1, 1, 2), 5, 1, 1);      // R3 R6 half width copy
        run_line(mk(8, 8, 3, 2, 2, 1), 100, 1, 1);    // R4 even mix
        run_line(mk(31, 20, 3, 3, 0, 3), 17, 1, 1);   // R5 clamp + saturate
        run_line(mk(16, 16, 0, 2, 0, 0), 200, 1, 1);  // R6 half on late line
        run_line(mk(0, 0, 1, 0, 0, 0), 63, 1, 1);     // R7 edge kept
        run_line(mk(0, 0, 1, 0, 0, 0), 64, 1, 1);     // R7 edge dropped
        run_line(mk(0, 0, 2, 1, 0, 0), 127, 1, 1);    // R7 edge kept
        run_line(mk(0, 0, 2, 1, 0, 0), 128, 1, 1);    // R7 edge dropped
        run_line(mk(0, 0, 3, 0, 0, 0), 262, 1, 1);    // R6 last line
        run_line(mk(0, 0, 3, 0, 0, 0), 10, 0, 1);     // R10 dst unmapped
        run_line(mk(0, 0, 3, 0, 1, 0), 11, 1, 0);     // R10 A ignores src B
        run_line(mk(0, 0, 3, 1, 0, 0), 12, 1, 0);     // R10 copy dropped
        run_line(mk(9, 9, 3, 2, 0, 0), 13, 1, 0);     // R10 mix dropped
        run_line(mk(4, 12, 3, 1, 3, 3), 255, 1, 1);   // R8 R9 wrap

        for (int i = 0; i < 30; i++) begin
            run_line(18'($urandom), int'($urandom % 263),
                     ($urandom % 8) != 0, ($urandom % 8) != 0);
        end
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule